// File: doc/BRIEF.md
# SD Card Initialization Sequencer

This block brings a freshly powered SD card from the idle state to a selected, 4-bit-wide, ready-for-transfer card. It does this by issuing a fixed series of command requests to an external command engine, which serializes them on the card lines and returns a done flag, a failure flag (timeout or CRC) and up to four 32-bit response registers. The sequencer reads the engine's results and picks the next step. It also owns the card clock divider setting and the controller's wide-bus flag.

A pulse on `start` launches the sequence. The block first sets the identification-speed divider, resets the card and waits a settle time. It then checks for a version 2 card and polls the operating conditions under a time limit. After that it reads the identification and card-specific registers, obtains the relative address, switches to full speed, selects the card and waits for the transfer state. Last, it sets the 4-bit bus and releases the pull-up on the data-3 line.

When the sequence ends, `fin` pulses for one cycle. `err_code` carries 0 on success or a negative step code on failure. The settle time and the time limits are counted in ticks of a prescaled counter, so simulation can shorten them.

Top module: `sd_init_seq`

## Requirements
- R1: `start` loads `clk_div` with DIV_IDENT (default 60) before the first request. `clk_div` becomes 0 once the address step completes, so every request from CMD9 onward sees 0.
- R2: The first request is index 0 with response-expected 0, long 0 and init flag 1. The next request starts no earlier than SETTLE_TICKS×TICK_DIV cycles after it.
- R3: Index 8 is sent with argument 0x1AA and a short response. The card counts as version 2 (`card_v2`=1) only when the engine reports success and response bits [11:0] equal 0x1AA. A failed index 8 is not an error.
- R4: Every application command (indices 41, 6, 42) comes directly after an index 55 request whose argument is {rca,16'h0}. A failed index 55 fails that step.
- R5: Index 41 carries argument 0x00FF8000, with bit 30 also set for a version 2 card. The pair 55/41 repeats until response bit 31 is 1, and the last response is kept in `ocr`.
- R6: If the 55/41 polling is still running more than OPCOND_TICKS ticks after index 8 completes, the sequence ends with `err_code` 0xFE (-2).
- R7: Index 2 uses a long response, and `cid` stores response register 3 as word 0 (`cid[31:0]`) and register 0 as word 3. Index 3 sets `rca` to response bits [31:16].
- R8: If `other_valid` is 1 and the new `rca` equals `other_rca`, index 3 is issued exactly once more. The second result is kept whatever its value.
- R9: Index 9 (long response, stored word-reversed in `csd`) and index 7 both carry {rca,16'h0}. Index 13 with the same argument then repeats until response bits [12:9] equal 4.
- R10: Index 6 is sent with argument 2 and index 42 with argument 0. When index 42 succeeds, `wide_bus` and `card_ok` become 1 and `fin` pulses with `err_code` 0.
- R11: Each failure ends the sequence with `fin`, `busy` low and its own code: index 0 0xFF, 55/41 failure 0xFD, index 2 0xFC, index 3 0xFB (0xFA on the reissue), index 9 0xF5, index 7 0xF4, transfer wait 0xF3, ACMD6 step 0xF1, ACMD42 step 0xEF.
- R12: `start` has no effect while `busy` is 1.
- R13: The transfer wait fails with 0xF3 after STAT_RETRIES failed index 13 requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch the sequence (ignored while busy) |
| other_valid | input | 1 | The other slot holds a valid address |
| other_rca | input | 16 | Address held by the other slot |
| cmd_start | output | 1 | One-cycle request strobe to the engine |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_resp_exp | output | 1 | A response is expected |
| cmd_long | output | 1 | The response is 136-bit (four words) |
| cmd_init | output | 1 | Send the initialization clocks first |
| cmd_done | input | 1 | Engine finished the request |
| cmd_fail | input | 1 | Request ended in timeout or CRC error |
| cmd_rsp | input | 128 | Response registers 0..3, register n in bits [32n+31:32n] |
| clk_div | output | 8 | Card clock divider setting |
| wide_bus | output | 1 | Controller 4-bit bus flag |
| busy | output | 1 | Sequence in progress |
| fin | output | 1 | One-cycle end-of-sequence pulse |
| err_code | output | 8 | 0 or a negative step code (two's complement) |
| card_ok | output | 1 | Card fully initialized |
| card_v2 | output | 1 | Card passed the interface-condition check |
| ocr | output | 32 | Operating conditions |
| cid | output | 128 | Identification register, word-reversed |
| rca | output | 16 | Relative card address |
| csd | output | 128 | Card-specific data, word-reversed |

## Verification
The hardest conditions to reach are the ones that depend on time or on a second slot: the operating-condition limit, the address collision and the retry budget of the transfer wait. The bench reaches them with a behavioural card model whose personality is set per run. In one run the card never leaves the busy state, so the tick limit trips. In another it hands out an address equal to the other slot's and then a fresh one. In a third it fails every status poll, or fails only the application prefix after selection. Each run loads an expected request script, and the model checks every request against the script as it arrives.

// File: rtl/sdi_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the SD initialization sequencer: step encoding,
// command indices, step failure codes and response word reordering.
package sdi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_GO, ST_SETTLE, ST_IFC, ST_OPC_APP, ST_OPC, ST_CID,
        ST_ADDR, ST_CSD, ST_SEL, ST_STAT, ST_BW_APP, ST_BW, ST_DET_APP, ST_DET
    } step_e;

    localparam logic [5:0] IX_GO   = 6'd0;
    localparam logic [5:0] IX_CID  = 6'd2;
    localparam logic [5:0] IX_ADDR = 6'd3;
    localparam logic [5:0] IX_BW   = 6'd6;
    localparam logic [5:0] IX_SEL  = 6'd7;
    localparam logic [5:0] IX_IFC  = 6'd8;
    localparam logic [5:0] IX_CSD  = 6'd9;
    localparam logic [5:0] IX_STAT = 6'd13;
    localparam logic [5:0] IX_OPC  = 6'd41;
    localparam logic [5:0] IX_DET  = 6'd42;
    localparam logic [5:0] IX_APP  = 6'd55;

    localparam logic [7:0] E_GO       = 8'hFF;
    localparam logic [7:0] E_OPC_TIME = 8'hFE;
    localparam logic [7:0] E_OPC      = 8'hFD;
    localparam logic [7:0] E_CID      = 8'hFC;
    localparam logic [7:0] E_ADDR     = 8'hFB;
    localparam logic [7:0] E_READDR   = 8'hFA;
    localparam logic [7:0] E_CSD      = 8'hF5;
    localparam logic [7:0] E_SEL      = 8'hF4;
    localparam logic [7:0] E_STAT     = 8'hF3;
    localparam logic [7:0] E_BW       = 8'hF1;
    localparam logic [7:0] E_DET      = 8'hEF;

    localparam logic [3:0] CARD_TRAN = 4'd4;

    // Place the highest-numbered response register at word 0.
    function automatic logic [127:0] flip_words(input logic [127:0] r);
        return {r[31:0], r[63:32], r[95:64], r[127:96]};
    endfunction

endpackage

// File: rtl/sdi_timer.sv
`timescale 1ns/1ps
// Tick timer: a prescaler of DIV cycles feeds a saturating tick count.
// Assumes clr is a single-cycle request; ticks reads 0 the cycle after.
module sdi_timer #(
    parameter int DIV = 24000,
    parameter int CAP = 5001,
    parameter int W   = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] ticks
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre;

    // Prescale the clock and count ticks up to CAP.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre   <= '0;
            ticks <= '0;
        end else if (pre == PW'(DIV - 1)) begin
            pre <= '0;
            if (ticks != W'(CAP)) ticks <= ticks + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // R6
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (ticks == $past(ticks) || ticks == $past(ticks) + 1'b1));
endmodule

// File: rtl/sdi_cmd_port.sv
`timescale 1ns/1ps
// Command engine port: registers each request and strobes it for one cycle,
// then captures the engine's completion, failure and response words.
// Assumes the engine answers each request with exactly one done pulse.
module sdi_cmd_port (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic [5:0]   req_idx,
    input  logic [31:0]  req_arg,
    input  logic         req_resp,
    input  logic         req_long,
    input  logic         req_init,
    input  logic         eng_done,
    input  logic         eng_fail,
    input  logic [127:0] eng_rsp,
    output logic         cmd_start,
    output logic [5:0]   cmd_idx,
    output logic [31:0]  cmd_arg,
    output logic         cmd_resp_exp,
    output logic         cmd_long,
    output logic         cmd_init,
    output logic         done_q,
    output logic         fail_q,
    output logic [127:0] rsp_q
);
    import sdi_pkg::*;

    logic       outstanding;
    logic [5:0] last_idx;

    // Launch requests and capture their completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_start    <= 1'b0;
            cmd_idx      <= '0;
            cmd_arg      <= '0;
            cmd_resp_exp <= 1'b0;
            cmd_long     <= 1'b0;
            cmd_init     <= 1'b0;
            done_q       <= 1'b0;
            fail_q       <= 1'b0;
            rsp_q        <= '0;
            outstanding  <= 1'b0;
            last_idx     <= '0;
        end else begin
            cmd_start <= issue;
            done_q    <= eng_done && outstanding;
            if (issue) begin
                cmd_idx      <= req_idx;
                cmd_arg      <= req_arg;
                cmd_resp_exp <= req_resp;
                cmd_long     <= req_long;
                cmd_init     <= req_init;
                outstanding  <= 1'b1;
            end
            if (eng_done && outstanding) begin
                fail_q      <= eng_fail;
                rsp_q       <= eng_rsp;
                outstanding <= 1'b0;
            end
            if (cmd_start) last_idx <= cmd_idx;
        end
    end

    // R2
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !outstanding);

    // R4
    app_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && (cmd_idx == IX_OPC || cmd_idx == IX_BW || cmd_idx == IX_DET))
        |-> last_idx == IX_APP);
endmodule

// File: rtl/sd_init_seq.sv
`timescale 1ns/1ps
// SD card initialization sequencer. Walks a card from reset to a selected,
// 4-bit-wide state through a command engine. Assumes the engine returns one
// done pulse per request, with response register n in cmd_rsp[32n+31:32n].
module sd_init_seq #(
    parameter int TICK_DIV      = 24000,
    parameter int SETTLE_TICKS  = 1,
    parameter int OPCOND_TICKS  = 1000,
    parameter int TRAN_TICKS    = 5000,
    parameter int STAT_RETRIES  = 10,
    parameter int DIV_IDENT     = 60
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         other_valid,
    input  logic [15:0]  other_rca,
    output logic         cmd_start,
    output logic [5:0]   cmd_idx,
    output logic [31:0]  cmd_arg,
    output logic         cmd_resp_exp,
    output logic         cmd_long,
    output logic         cmd_init,
    input  logic         cmd_done,
    input  logic         cmd_fail,
    input  logic [127:0] cmd_rsp,
    output logic [7:0]   clk_div,
    output logic         wide_bus,
    output logic         busy,
    output logic         fin,
    output logic [7:0]   err_code,
    output logic         card_ok,
    output logic         card_v2,
    output logic [31:0]  ocr,
    output logic [127:0] cid,
    output logic [15:0]  rca,
    output logic [127:0] csd
);
    import sdi_pkg::*;

    localparam int LIM_A  = (OPCOND_TICKS > TRAN_TICKS) ? OPCOND_TICKS : TRAN_TICKS;
    localparam int LIM    = (LIM_A > SETTLE_TICKS) ? LIM_A : SETTLE_TICKS;
    localparam int TICK_W = $clog2(LIM + 2);
    localparam int SFW    = $clog2(STAT_RETRIES + 1);

    step_e           st;
    logic            waiting, readdr, tmr_clr_q;
    logic [SFW-1:0]  stat_fails;
    logic [TICK_W-1:0] ticks;
    logic            done_q, fail_q;
    logic [127:0]    rsp_q;
    logic            in_cmd, issue, opc_late, fail_hit, collide, is_tran;
    logic [5:0]      r_idx;
    logic [31:0]     r_arg;
    logic            r_resp, r_long, r_init;
    logic [7:0]      code;

    sdi_timer #(.DIV(TICK_DIV), .CAP(LIM + 1), .W(TICK_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr_q), .ticks(ticks));

    sdi_cmd_port u_port (
        .clk(clk), .rst_n(rst_n), .issue(issue),
        .req_idx(r_idx), .req_arg(r_arg), .req_resp(r_resp),
        .req_long(r_long), .req_init(r_init),
        .eng_done(cmd_done), .eng_fail(cmd_fail), .eng_rsp(cmd_rsp),
        .cmd_start(cmd_start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .cmd_resp_exp(cmd_resp_exp), .cmd_long(cmd_long), .cmd_init(cmd_init),
        .done_q(done_q), .fail_q(fail_q), .rsp_q(rsp_q));

    // Select the request that belongs to the current step.
    always_comb begin
        in_cmd = 1'b1;
        r_idx  = IX_GO;
        r_arg  = {rca, 16'h0000};
        r_resp = 1'b1;
        r_long = 1'b0;
        r_init = 1'b0;
        unique case (st)
            ST_GO:      begin r_idx = IX_GO; r_arg = '0; r_resp = 1'b0; r_init = 1'b1; end
            ST_IFC:     begin r_idx = IX_IFC; r_arg = 32'h0000_01AA; end
            ST_OPC_APP, ST_BW_APP, ST_DET_APP: r_idx = IX_APP;
            ST_OPC:     begin r_idx = IX_OPC; r_arg = 32'h00FF_8000 | {1'b0, card_v2, 30'b0}; end
            ST_CID:     begin r_idx = IX_CID; r_arg = '0; r_long = 1'b1; end
            ST_ADDR:    begin r_idx = IX_ADDR; r_arg = '0; end
            ST_CSD:     begin r_idx = IX_CSD; r_long = 1'b1; end
            ST_SEL:     r_idx = IX_SEL;
            ST_STAT:    r_idx = IX_STAT;
            ST_BW:      begin r_idx = IX_BW; r_arg = 32'd2; end
            ST_DET:     begin r_idx = IX_DET; r_arg = '0; end
            default:    in_cmd = 1'b0;
        endcase
    end

    assign opc_late = (st == ST_OPC_APP) && !tmr_clr_q && !waiting &&
                      (ticks > TICK_W'(OPCOND_TICKS));
    assign issue    = in_cmd && !waiting && !tmr_clr_q && !opc_late;
    assign collide  = other_valid && (rsp_q[31:16] == other_rca) && !readdr;
    assign is_tran  = (rsp_q[12:9] == CARD_TRAN);

    // Decide whether this cycle ends the sequence with a failure code.
    always_comb begin
        fail_hit = 1'b0;
        code     = 8'h00;
        if (opc_late) begin
            fail_hit = 1'b1;
            code     = E_OPC_TIME;
        end else if (done_q && fail_q) begin
            fail_hit = 1'b1;
            unique case (st)
                ST_GO:                 code = E_GO;
                ST_OPC_APP, ST_OPC:    code = E_OPC;
                ST_CID:                code = E_CID;
                ST_ADDR:               code = readdr ? E_READDR : E_ADDR;
                ST_CSD:                code = E_CSD;
                ST_SEL:                code = E_SEL;
                ST_STAT: begin
                    code     = E_STAT;
                    fail_hit = (32'(stat_fails) + 1 >= STAT_RETRIES);
                end
                ST_BW_APP, ST_BW:      code = E_BW;
                ST_DET_APP, ST_DET:    code = E_DET;
                default:               fail_hit = 1'b0;
            endcase
        end else if (done_q && st == ST_STAT && !is_tran &&
                     ticks > TICK_W'(TRAN_TICKS)) begin
            fail_hit = 1'b1;
            code     = E_STAT;
        end
    end

    // Step sequencing, stored card registers and the clock/bus settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; waiting <= 1'b0; readdr <= 1'b0; tmr_clr_q <= 1'b0;
            stat_fails <= '0; clk_div <= '0; wide_bus <= 1'b0; busy <= 1'b0;
            fin <= 1'b0; err_code <= '0; card_ok <= 1'b0; card_v2 <= 1'b0;
            ocr <= '0; cid <= '0; rca <= '0; csd <= '0;
        end else begin
            fin       <= 1'b0;
            tmr_clr_q <= 1'b0;
            if (issue) waiting <= 1'b1;
            else if (done_q) waiting <= 1'b0;
            if (fail_hit) begin
                st <= ST_IDLE; busy <= 1'b0; fin <= 1'b1; err_code <= code;
            end else begin
                unique case (st)
                    ST_IDLE: if (start) begin
                        st <= ST_GO; busy <= 1'b1; clk_div <= 8'(DIV_IDENT);
                        wide_bus <= 1'b0; card_ok <= 1'b0; card_v2 <= 1'b0;
                        rca <= '0; readdr <= 1'b0; waiting <= 1'b0; err_code <= '0;
                    end
                    ST_GO: if (done_q) begin st <= ST_SETTLE; tmr_clr_q <= 1'b1; end
                    ST_SETTLE: if (!tmr_clr_q && ticks >= TICK_W'(SETTLE_TICKS)) st <= ST_IFC;
                    ST_IFC: if (done_q) begin
                        card_v2   <= !fail_q && (rsp_q[11:0] == 12'h1AA);
                        st        <= ST_OPC_APP;
                        tmr_clr_q <= 1'b1;
                    end
                    ST_OPC_APP: if (done_q) st <= ST_OPC;
                    ST_OPC: if (done_q) begin
                        ocr <= rsp_q[31:0];
                        st  <= rsp_q[31] ? ST_CID : ST_OPC_APP;
                    end
                    ST_CID: if (done_q) begin cid <= flip_words(rsp_q); st <= ST_ADDR; end
                    ST_ADDR: if (done_q) begin
                        rca <= rsp_q[31:16];
                        if (collide) readdr <= 1'b1;
                        else begin clk_div <= '0; st <= ST_CSD; end
                    end
                    ST_CSD: if (done_q) begin csd <= flip_words(rsp_q); st <= ST_SEL; end
                    ST_SEL: if (done_q) begin
                        st <= ST_STAT; tmr_clr_q <= 1'b1; stat_fails <= '0;
                    end
                    ST_STAT: if (done_q) begin
                        if (fail_q) stat_fails <= stat_fails + 1'b1;
                        else if (is_tran) st <= ST_BW_APP;
                    end
                    ST_BW_APP:  if (done_q) st <= ST_BW;
                    ST_BW:      if (done_q) st <= ST_DET_APP;
                    ST_DET_APP: if (done_q) st <= ST_DET;
                    ST_DET: if (done_q) begin
                        wide_bus <= 1'b1; card_ok <= 1'b1; busy <= 1'b0;
                        fin <= 1'b1; err_code <= 8'h00; st <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R1
    div_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_div) |-> (clk_div == 8'h00 || clk_div == 8'(DIV_IDENT)));

    // R1
    fast_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_idx == IX_CSD) |-> clk_div == 8'h00);

    // R10
    wide_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wide_bus) |-> (fin && err_code == 8'h00 && card_ok));

    // R6
    opc_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && err_code == E_OPC_TIME) |-> ticks > TICK_W'(OPCOND_TICKS));

    // R12
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !fail_hit && st != ST_DET) |=> busy);
endmodule

// File: tb/sim_sd_init_seq.sv
`timescale 1ns/1ps
// Bench: a behavioural card model answers each request and checks it
// against an expected request script loaded per run.
module sim_sd_init_seq;
    localparam int TD = 4, ST_T = 5, OP_T = 40, TR_T = 40, RET = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic other_valid = 1'b0;
    logic [15:0] other_rca = '0;
    logic cmd_done = 1'b0, cmd_fail = 1'b0;
    logic [127:0] cmd_rsp = '0;
    logic cmd_start, cmd_resp_exp, cmd_long, cmd_init;
    logic [5:0] cmd_idx;
    logic [31:0] cmd_arg, ocr;
    logic [7:0] clk_div, err_code;
    logic wide_bus, busy, fin, card_ok, card_v2;
    logic [127:0] cid, csd;
    logic [15:0] rca;

    sd_init_seq #(.TICK_DIV(TD), .SETTLE_TICKS(ST_T), .OPCOND_TICKS(OP_T),
                  .TRAN_TICKS(TR_T), .STAT_RETRIES(RET), .DIV_IDENT(60)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .other_valid(other_valid),
        .other_rca(other_rca), .cmd_start(cmd_start), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .cmd_resp_exp(cmd_resp_exp), .cmd_long(cmd_long),
        .cmd_init(cmd_init), .cmd_done(cmd_done), .cmd_fail(cmd_fail),
        .cmd_rsp(cmd_rsp), .clk_div(clk_div), .wide_bus(wide_bus), .busy(busy),
        .fin(fin), .err_code(err_code), .card_ok(card_ok), .card_v2(card_v2),
        .ocr(ocr), .cid(cid), .rca(rca), .csd(csd));

    always #2.5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    always @(posedge clk) cyc++;

    // Card personality and script state.
    int c8mode, busy41, nontran, n0, cyc0, cyc8, fin_cyc, n3;
    bit fail0, fail13, fail55_late, seen13, after3, script_on, poke;
    logic [15:0] rca_list [2];
    logic [40:0] exp_q [$];

    localparam logic [127:0] CID_RSP = {32'hC1D0_0003, 32'hC1D0_0002, 32'hC1D0_0001, 32'hC1D0_0000};
    localparam logic [127:0] CSD_RSP = {32'h5E50_0003, 32'h5E50_0002, 32'h5E50_0001, 32'h5E50_0000};

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] i);
        case (i)
            6'd0: return "R2";  6'd8: return "R3";  6'd55: return "R4";
            6'd41: return "R5"; 6'd2, 6'd3: return "R7";
            6'd6, 6'd42: return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic push(input logic [5:0] i, input logic [31:0] a, input logic [2:0] f);
        exp_q.push_back({i, a, f});
    endtask

    // Card model: check each request, then answer two cycles later.
    always begin
        @(negedge clk);
        if (cmd_start) begin
            automatic logic [5:0] i = cmd_idx;
            automatic logic [40:0] got = {cmd_idx, cmd_arg, cmd_resp_exp, cmd_long, cmd_init};
            automatic logic [127:0] r = '0;
            automatic bit f = 1'b0;
            if (i == 6'd0) begin n0++; cyc0 = cyc; end
            if (i == 6'd8) cyc8 = cyc;
            if (i == 6'd9) after3 = 1'b1;
            // R1: divider seen by each request
            check(clk_div == (after3 ? 8'd0 : 8'd60), "R1", clk_div, after3 ? 0 : 60);
            if (script_on) begin
                if (exp_q.size() == 0) check(1'b0, tag_of(i), got, 0);
                else begin
                    automatic logic [40:0] e = exp_q.pop_front();
                    check(got == e, tag_of(i), got, e);
                end
            end
            case (i)
                6'd0:  f = fail0;
                6'd8:  begin f = (c8mode == 0); r[31:0] = (c8mode == 1) ? 32'h1AA : 32'h2AA; end
                6'd55: begin f = fail55_late && seen13; r[31:0] = 32'h120; end
                6'd41: begin
                    r[31:0] = (busy41 > 0) ? 32'h00FF8000 :
                              (32'h80FF8000 | ((c8mode == 1) ? 32'h4000_0000 : 0));
                    if (busy41 > 0) busy41--;
                end
                6'd2:  r = CID_RSP;
                6'd3:  begin r[31:0] = {rca_list[n3], 16'h0500}; if (n3 == 0) n3 = 1; end
                6'd9:  r = CSD_RSP;
                6'd13: begin
                    seen13 = 1'b1; f = fail13;
                    r[31:0] = (nontran > 0) ? 32'h0000_0600 : 32'h0000_0800;
                    if (nontran > 0) nontran--;
                end
                default: r[31:0] = 32'h920;
            endcase
            if (poke && i == 6'd8) begin start = 1'b1; poke = 1'b0; end
            @(negedge clk); start = 1'b0;
            @(negedge clk); cmd_done = 1'b1; cmd_fail = f; cmd_rsp = r;
            @(negedge clk); cmd_done = 1'b0; cmd_fail = 1'b0;
        end
    end

    task automatic setup(input int m8, input int b41, input int nt);
        c8mode = m8; busy41 = b41; nontran = nt; n0 = 0; n3 = 0;
        fail0 = 0; fail13 = 0; fail55_late = 0; seen13 = 0; after3 = 0;
        script_on = 1; poke = 0; exp_q.delete();
    endtask

    task automatic go(input string req);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            if (fin) break;
            @(negedge clk);
        end
        fin_cyc = cyc;
        check(fin === 1'b1, req, fin, 1);
        @(negedge clk);
        check(busy == 1'b0, req, busy, 0);
    endtask

    bit finished = 0;
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check({busy, wide_bus, card_ok, cmd_start} == 4'b0 && clk_div == 0 && err_code == 0,
              "R12", {busy, wide_bus, card_ok, clk_div}, 0);

        // Run A: version 2 card, two busy polls, one non-transfer status poll
        setup(1, 2, 1); poke = 1;
        push(0, 0, 3'b001); push(8, 32'h1AA, 3'b100);
        for (int k = 0; k < 3; k++) begin push(55, 0, 3'b100); push(41, 32'h40FF8000, 3'b100); end
        push(2, 0, 3'b110); push(3, 0, 3'b100);
        push(9, 32'h12340000, 3'b110); push(7, 32'h12340000, 3'b100);
        push(13, 32'h12340000, 3'b100); push(13, 32'h12340000, 3'b100);
        push(55, 32'h12340000, 3'b100); push(6, 2, 3'b100);
        push(55, 32'h12340000, 3'b100); push(42, 0, 3'b100);
        rca_list[0] = 16'h1234; rca_list[1] = 16'h1234;
        go("R10");
        check(err_code == 0 && card_ok && wide_bus, "R10", {err_code, card_ok, wide_bus}, 3);
        check(clk_div == 0, "R1", clk_div, 0);
        check(card_v2 == 1, "R3", card_v2, 1);
        check(ocr == 32'hC0FF8000, "R5", ocr, 32'hC0FF8000);
        check(cid[31:0] == 32'hC1D00003 && cid[127:96] == 32'hC1D00000, "R7", cid, 0);
        check(rca == 16'h1234, "R7", rca, 16'h1234);
        check(csd[31:0] == 32'h5E500003 && csd[127:96] == 32'h5E500000, "R9", csd, 0);
        check(exp_q.size() == 0, "R9", exp_q.size(), 0);
        check(n0 == 1, "R12", n0, 1);
        check(cyc8 - cyc0 >= ST_T * TD, "R2", cyc8 - cyc0, ST_T * TD);

        // Run B: version 1 card, address collides with the other slot
        setup(0, 0, 0); other_valid = 1; other_rca = 16'h1234;
        rca_list[0] = 16'h1234; rca_list[1] = 16'h5678;
        push(0, 0, 3'b001); push(8, 32'h1AA, 3'b100);
        push(55, 0, 3'b100); push(41, 32'h00FF8000, 3'b100);
        push(2, 0, 3'b110); push(3, 0, 3'b100); push(3, 0, 3'b100);
        push(9, 32'h56780000, 3'b110); push(7, 32'h56780000, 3'b100);
        push(13, 32'h56780000, 3'b100);
        push(55, 32'h56780000, 3'b100); push(6, 2, 3'b100);
        push(55, 32'h56780000, 3'b100); push(42, 0, 3'b100);
        go("R8");
        check(rca == 16'h5678 && err_code == 0, "R8", {rca, err_code}, {16'h5678, 8'h0});
        check(card_v2 == 0, "R3", card_v2, 0);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);
        other_valid = 0;

        // Run C: wrong echo and a card that never leaves busy
        setup(2, 100000, 0); script_on = 0;
        go("R6");
        check(err_code == 8'hFE, "R6", err_code, 8'hFE);
        check(fin_cyc - cyc8 >= OP_T * TD, "R6", fin_cyc - cyc8, OP_T * TD);
        check(card_v2 == 0 && wide_bus == 0 && card_ok == 0, "R3", {card_v2, wide_bus, card_ok}, 0);

        // Run D: application prefix fails after selection
        setup(1, 0, 0); script_on = 0; fail55_late = 1;
        go("R11");
        check(err_code == 8'hF1 && !card_ok && !wide_bus, "R11", err_code, 8'hF1);

        // Run E: reset command fails
        setup(1, 0, 0); script_on = 0; fail0 = 1;
        go("R11");
        check(err_code == 8'hFF && n0 == 1, "R11", err_code, 8'hFF);

        // Run F: every status poll fails
        setup(1, 0, 0); script_on = 0; fail13 = 1;
        go("R13");
        check(err_code == 8'hF3, "R13", err_code, 8'hF3);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule